// File: doc/BRIEF.md
# Calibrated BCD Calendar Counter

This block keeps the time of day and the calendar date as packed BCD words. A slow tick input, nominally 32.768 kHz and presented as a one-cycle pulse in the system clock domain, feeds a prescaler. A 16-bit calibration value sets how many ticks make one second, so firmware can trim the clock's rate. Each completed second advances the seconds field and carries into minutes, hours, day, month and a two-digit year. Day rollover follows month lengths and leap years.

Time and date are set together. The host stages a time word and a date word, then pulses the update strobe. Both live words take the staged values on the same clock edge, and the prescaler restarts from zero. An enable input freezes the whole block when it is low. A single-cycle seconds pulse marks every advance.

Top module: `bcdcal_top`

## Requirements
- R1: After reset the time word reads 00:00:00, the date word reads year 01, month 01, day 01 (0x00841 in the date encoding), `secPulse` is low and the calibration value in force is 0x7FFF.
- R2: A second lasts the in-force calibration value plus one enabled ticks. The default of 0x7FFF gives 32768 ticks.
- R3: `secPulse` is high for one clock cycle, in the first cycle the advanced seconds value is visible. Outside a load, the time and date words change only in such a cycle.
- R4: Time word layout: seconds BCD in bits [6:0], minutes in [13:7], hours in [20:14]. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries one into the next field.
- R5: Date word layout: day BCD in bits [5:0], month (01 to 12) in [10:6], year (00 to 99) in [18:11]. The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. The month wraps from 12 to 01.
- R6: In month 02 the day wraps after 29 when the year is a multiple of four (including 00), and after 28 otherwise.
- R7: One second after 99-12-31 23:59:59, the block reads 00-01-01 00:00:00.
- R8: An update strobe copies the staged time and date words into the live words on the next edge, takes the present calibration value and clears the prescaler, so the next second is a full one. The strobe wins over a second boundary in the same cycle, and no pulse is produced then.
- R9: While the enable is low, ticks are ignored. The prescaler count and the time and date hold their values, and counting resumes where it stopped once the enable is raised again.
- R10: A calibration value that changes in the middle of a second takes effect only at the next second boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle pulse per slow oscillator tick |
| enable | input | 1 | Counting enable; low freezes the block |
| calValue | input | 16 | Ticks per second minus one |
| stageTime | input | 21 | Staged BCD time word |
| stageDate | input | 19 | Staged BCD date word |
| updateStrobe | input | 1 | Loads both staged words and restarts the prescaler |
| timeWord | output | 21 | Live BCD time word |
| dateWord | output | 19 | Live BCD date word |
| secPulse | output | 1 | One-cycle pulse on each second advance |

## Verification
The hardest states to reach from the ports are the carries through day, month and year, because at the nominal rate they sit days or years of ticks apart. The stimulus loads a time one second before each boundary of interest, lowers the calibration value to zero or a few ticks, and then compares each advance with a bench calendar model. The cases are end of month for each month length, February in leap and common years, and the end of year 99. Two edge cases are placed with exact tick counts: a load on the very tick that ends a second, and a calibration change in the middle of a second. Random loads near 59 seconds drive the carry chain with random tick gaps.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

  localparam int FIELDS = 6;
  localparam int SEC    = 0;
  localparam int MIN    = 1;
  localparam int HOUR   = 2;
  localparam int DAY    = 3;
  localparam int MON    = 4;
  localparam int YEAR   = 5;
  localparam int TIME_W = 21;
  localparam int DATE_W = 19;

  typedef struct packed {
    logic load;
    logic advance;
  } calStrobe_t;

  function automatic int fieldWidth(input int i);
    case (i)
      DAY:     return 6;
      MON:     return 5;
      YEAR:    return 8;
      default: return 7;
    endcase
  endfunction

  function automatic int fieldLsb(input int i);
    case (i)
      MIN:     return 7;
      HOUR:    return 14;
      MON:     return 6;
      YEAR:    return 11;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] fieldFirst(input int i);
    return (i == DAY || i == MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fieldReset(input int i);
    return (i >= DAY) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] fieldLast(input int i);
    case (i)
      HOUR:    return 8'h23;
      MON:     return 8'h12;
      YEAR:    return 8'h99;
      default: return 8'h59;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yrBin;
    yrBin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (yrBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcdcal_ctrl.sv
module bcdcal_ctrl
  import bcdcal_pkg::*;
#(
  parameter int unsigned CAL_W = 16,
  parameter logic [CAL_W-1:0] NOMINAL_CAL = {1'b0, {(CAL_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             enable,
  input  logic [CAL_W-1:0] calValue,
  input  logic             updateStrobe,
  output calStrobe_t       strobes,
  output logic             secPulse
);

  logic [CAL_W-1:0] preCount;
  logic [CAL_W-1:0] calActive;
  logic             liveTick;
  logic             boundary;

  assign liveTick = tickIn && enable;
  assign boundary = liveTick && (preCount == calActive);

  always_comb begin
    strobes.load    = updateStrobe;
    strobes.advance = boundary && !updateStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCount  <= '0;
      calActive <= NOMINAL_CAL;
      secPulse  <= 1'b0;
    end else begin
      secPulse <= strobes.advance;
      if (updateStrobe) begin
        preCount  <= '0;
        calActive <= calValue;
      end else if (boundary) begin
        preCount  <= '0;
        calActive <= calValue;
      end else if (liveTick) begin
        preCount <= preCount + CAL_W'(1);
      end
    end
  end

endmodule

// File: rtl/bcdcal_datapath.sv
module bcdcal_datapath
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobes,
  input  logic [TIME_W-1:0] stageTime,
  input  logic [DATE_W-1:0] stageDate,
  output logic [TIME_W-1:0] timeWord,
  output logic [DATE_W-1:0] dateWord
);

  logic [FIELDS-1:0][7:0] cur;
  logic [FIELDS-1:0]      atLast;
  logic [FIELDS-1:0]      stepIn;

  always_comb begin
    stepIn[0] = strobes.advance;
    for (int k = 1; k < FIELDS; k++) stepIn[k] = stepIn[k-1] && atLast[k-1];
  end

  for (genvar i = 0; i < FIELDS; i++) begin : fieldGen
    localparam int W   = fieldWidth(i);
    localparam int LSB = fieldLsb(i);
    localparam logic [7:0] FIRST = fieldFirst(i);
    localparam logic [7:0] RESETV = fieldReset(i);

    logic [W-1:0] q;
    logic [W-1:0] ld;
    logic [7:0]   last;

    if (i < DAY) begin : fromTime
      assign ld = stageTime[LSB +: W];
      assign timeWord[LSB +: W] = q;
    end else begin : fromDate
      assign ld = stageDate[LSB +: W];
      assign dateWord[LSB +: W] = q;
    end

    if (i == DAY) begin : dynLast
      assign last = monthLast(cur[MON], cur[YEAR]);
    end else begin : fixLast
      assign last = fieldLast(i);
    end

    assign cur[i]    = 8'(q);
    assign atLast[i] = cur[i] >= last;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             q <= W'(RESETV);
      else if (strobes.load) q <= ld;
      else if (stepIn[i])    q <= atLast[i] ? W'(FIRST) : W'(bcdInc(cur[i]));
    end
  end

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
  import bcdcal_pkg::*;
#(
  parameter int unsigned CAL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             enable,
  input  logic [CAL_W-1:0] calValue,
  input  logic [20:0]      stageTime,
  input  logic [18:0]      stageDate,
  input  logic             updateStrobe,
  output logic [20:0]      timeWord,
  output logic [18:0]      dateWord,
  output logic             secPulse
);

  calStrobe_t strobes;

  bcdcal_ctrl #(.CAL_W(CAL_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .enable(enable),
    .calValue(calValue), .updateStrobe(updateStrobe),
    .strobes(strobes), .secPulse(secPulse)
  );

  bcdcal_datapath dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .stageTime(stageTime), .stageDate(stageDate),
    .timeWord(timeWord), .dateWord(dateWord)
  );

endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        updateStrobe,
  input logic [20:0] stageTime,
  input logic [18:0] stageDate,
  input logic [20:0] timeWord,
  input logic [18:0] dateWord,
  input logic        secPulse
);

  assert_pulse_moves_seconds_R3: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> (timeWord[6:0] != $past(timeWord[6:0])));

  assert_still_without_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    !updateStrobe |=> (secPulse || ($stable(timeWord) && $stable(dateWord))));

  assert_minute_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && timeWord[6:0] == 7'h00) |-> (timeWord[13:7] != $past(timeWord[13:7])));

  assert_load_copies_R8: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> (timeWord == $past(stageTime) && dateWord == $past(stageDate) && !secPulse));

  assert_frozen_when_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !updateStrobe) |=> ($stable(timeWord) && $stable(dateWord) && !secPulse));

endmodule

bind bcdcal_top bcdcal_checker chk (
  .clk(clk), .rstN(rstN), .enable(enable), .updateStrobe(updateStrobe),
  .stageTime(stageTime), .stageDate(stageDate),
  .timeWord(timeWord), .dateWord(dateWord), .secPulse(secPulse)
);

// File: tb/bcdcal_top_test.sv
module bcdcal_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] calValue = 16'h7FFF;
  logic [20:0] stageTime = '0;
  logic [18:0] stageDate = '0;
  logic        updateStrobe = 1'b0;
  logic [20:0] timeWord;
  logic [18:0] dateWord;
  logic        secPulse;

  int testsRun = 0;
  int testsFailed = 0;
  logic [20:0] expT;
  logic [18:0] expD;

  always #2 clk = ~clk;

  bcdcal_top uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .enable(enable), .calValue(calValue),
    .stageTime(stageTime), .stageDate(stageDate), .updateStrobe(updateStrobe),
    .timeWord(timeWord), .dateWord(dateWord), .secPulse(secPulse)
  );

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int daysIn(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [20:0] mkTime(input int h, input int m, input int s);
    logic [7:0] a, b, c;
    a = i2b(h); b = i2b(m); c = i2b(s);
    return {a[6:0], b[6:0], c[6:0]};
  endfunction

  function automatic logic [18:0] mkDate(input int y, input int mo, input int dy);
    logic [7:0] a, b, c;
    a = i2b(y); b = i2b(mo); c = i2b(dy);
    return {a, b[4:0], c[5:0]};
  endfunction

  function automatic logic [39:0] refNext(input logic [20:0] t, input logic [18:0] d);
    int s, m, h, dy, mo, y;
    s  = b2i({1'b0, t[6:0]});
    m  = b2i({1'b0, t[13:7]});
    h  = b2i({1'b0, t[20:14]});
    dy = b2i({2'b0, d[5:0]});
    mo = b2i({3'b0, d[10:6]});
    y  = b2i(d[18:11]);
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; dy++;
          if (dy > daysIn(mo, y)) begin
            dy = 1; mo++;
            if (mo == 13) begin
              mo = 1; y++;
              if (y == 100) y = 0;
            end
          end
        end
      end
    end
    return {mkDate(y, mo, dy), mkTime(h, m, s)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadClock(input logic [20:0] t, input logic [18:0] d, input bit withTick,
                           input string req);
    @(negedge clk);
    stageTime = t; stageDate = d; updateStrobe = 1'b1; tickIn = withTick;
    @(negedge clk);
    updateStrobe = 1'b0; tickIn = 1'b0;
    check(timeWord == t, req, "loaded time", 64'(timeWord), 64'(t));
    check(dateWord == d, req, "loaded date", 64'(dateWord), 64'(d));
    check(secPulse == 1'b0, req, "no pulse on load", 64'(secPulse), 64'd0);
    expT = t; expD = d;
  endtask

  task automatic tickN(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
      check(secPulse == 1'b0, req, "early pulse", 64'(secPulse), 64'd0);
      check(timeWord == expT, req, "time held", 64'(timeWord), 64'(expT));
    end
  endtask

  task automatic runSecond(input int expTicks, input int gapMax, input string req);
    int n = 0;
    bit got = 1'b0;
    logic [39:0] nx;
    nx = refNext(expT, expD);
    while (!got && n < 70000) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
      n++;
      got = secPulse;
      if (!got && gapMax > 0) repeat ($urandom % (gapMax + 1)) @(negedge clk);
    end
    check(n == expTicks, req, "ticks per second", 64'(n), 64'(expTicks));
    check(timeWord == nx[20:0], req, "time after advance", 64'(timeWord), 64'(nx[20:0]));
    check(dateWord == nx[39:21], req, "date after advance", 64'(dateWord), 64'(nx[39:21]));
    expT = nx[20:0]; expD = nx[39:21];
    @(negedge clk);
    check(secPulse == 1'b0, "R3", "pulse width", 64'(secPulse), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(timeWord == 21'h0, "R1", "reset time", 64'(timeWord), 64'd0);
    check(dateWord == 19'h00841, "R1", "reset date", 64'(dateWord), 64'h841);
    check(secPulse == 1'b0, "R1", "reset pulse", 64'(secPulse), 64'd0);
    expT = 21'h0; expD = 19'h00841;
    enable = 1'b1;

    // R1 / R2: nominal calibration after reset
    runSecond(32768, 0, "R2");

    // R4: hour and day carry
    calValue = 16'd3;
    loadClock(mkTime(23, 59, 58), mkDate(24, 12, 31), 1'b0, "R8");
    runSecond(4, 2, "R4");
    runSecond(4, 2, "R4");
    check(dateWord == mkDate(25, 1, 1), "R4", "year carry", 64'(dateWord), 64'(mkDate(25, 1, 1)));

    // R7: end of range wrap
    calValue = 16'd0;
    loadClock(mkTime(23, 59, 59), mkDate(99, 12, 31), 1'b0, "R8");
    runSecond(1, 0, "R7");
    check(timeWord == 21'h0 && dateWord == mkDate(0, 1, 1), "R7", "full wrap",
          64'({dateWord, timeWord}), 64'({mkDate(0, 1, 1), 21'h0}));

    // R6: February
    loadClock(mkTime(23, 59, 59), mkDate(23, 2, 28), 1'b0, "R8");
    runSecond(1, 0, "R6");
    check(dateWord == mkDate(23, 3, 1), "R6", "common year", 64'(dateWord), 64'(mkDate(23, 3, 1)));
    loadClock(mkTime(23, 59, 59), mkDate(24, 2, 28), 1'b0, "R8");
    runSecond(1, 0, "R6");
    check(dateWord == mkDate(24, 2, 29), "R6", "leap day", 64'(dateWord), 64'(mkDate(24, 2, 29)));
    loadClock(mkTime(23, 59, 59), mkDate(24, 2, 29), 1'b0, "R8");
    runSecond(1, 0, "R6");
    loadClock(mkTime(23, 59, 59), mkDate(0, 2, 28), 1'b0, "R8");
    runSecond(1, 0, "R6");

    // R5: month lengths
    loadClock(mkTime(23, 59, 59), mkDate(23, 4, 30), 1'b0, "R8");
    runSecond(1, 0, "R5");
    check(dateWord == mkDate(23, 5, 1), "R5", "30-day month", 64'(dateWord), 64'(mkDate(23, 5, 1)));
    loadClock(mkTime(23, 59, 59), mkDate(23, 1, 31), 1'b0, "R8");
    runSecond(1, 0, "R5");
    loadClock(mkTime(23, 59, 59), mkDate(23, 11, 30), 1'b0, "R8");
    runSecond(1, 0, "R5");
    loadClock(mkTime(23, 59, 59), mkDate(23, 8, 30), 1'b0, "R8");
    runSecond(1, 0, "R5");
    check(dateWord == mkDate(23, 8, 31), "R5", "31-day month", 64'(dateWord), 64'(mkDate(23, 8, 31)));

    // R9: enable low freezes prescaler and counters
    calValue = 16'd3;
    loadClock(mkTime(10, 20, 30), mkDate(30, 6, 15), 1'b0, "R8");
    tickN(2, "R9");
    enable = 1'b0;
    tickN(5, "R9");
    check(dateWord == expD, "R9", "date held", 64'(dateWord), 64'(expD));
    enable = 1'b1;
    runSecond(2, 0, "R9");

    // R10: calibration change mid-second
    loadClock(mkTime(1, 2, 3), mkDate(40, 3, 3), 1'b0, "R8");
    tickN(1, "R10");
    calValue = 16'd1;
    runSecond(3, 0, "R10");
    runSecond(2, 0, "R10");

    // R8: load on a boundary tick, then a full second
    calValue = 16'd3;
    loadClock(mkTime(5, 5, 5), mkDate(41, 4, 4), 1'b0, "R8");
    tickN(3, "R8");
    loadClock(mkTime(12, 34, 56), mkDate(42, 7, 8), 1'b1, "R8");
    runSecond(4, 0, "R8");

    // random loads near carries
    for (int it = 0; it < 25; it++) begin
      int y, mo, dy, h, m, s, cal, nsec, dim;
      cal  = int'($urandom % 6);
      y    = int'($urandom % 100);
      mo   = 1 + int'($urandom % 12);
      dim  = daysIn(mo, y);
      dy   = ($urandom % 2 == 0) ? dim : 1 + int'($urandom % dim);
      h    = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      m    = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s    = 55 + int'($urandom % 5);
      nsec = 1 + int'($urandom % 3);
      calValue = 16'(cal);
      loadClock(mkTime(h, m, s), mkDate(y, mo, dy), 1'b0, "R8");
      for (int j = 0; j < nsec; j++) runSecond(cal + 1, 3, "R4");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule